// File: doc/BRIEF.md
# SMBus Byte Register Slave

This block is an SMBus slave. It lets a host read and write single bytes in a register file that sits next to it. The block watches the SCL and SDA lines, which run asynchronously to the system clock, through two-flop synchronizers. It pulls SDA low through an open-drain enable and never drives SCL. Its own 7-bit bus address comes in on a port, normally set by strap pins.

The block accepts only two transactions.
- Write Byte: address with the write bit, then a register pointer, then one data byte, then STOP.
- Read Byte: address with the write bit, then a register pointer, then a repeated START, then address with the read bit. The slave returns one byte and the host ends with NACK and STOP.

The register file is outside the block. The block presents a register pointer on `reg_addr` and receives that register's contents and a "register exists" flag in return. A write reaches the register file only as a one-cycle strobe at the closing STOP.

A separate alert request sets a pending flag, which drives the active-low alert output. While that flag is set, the slave also answers the alert response address and returns its own address. The flag clears once that transfer has been acknowledged.

Top module: `smb_reg_slave`

## Requirements
- R1: A complete Write Byte (START, `{dev_addr,0}`, pointer, data, STOP) to a defined register gets ACK on all three bytes. It produces exactly one `reg_we` pulse, carrying the pointer and the data, in the cycle after the synchronized STOP is detected.
- R2: A Read Byte to a defined register gets ACK on both address bytes and on the pointer. It returns that register's value MSB first.
- R3: A write to an undefined register (`reg_defined` low) still gets ACK on all three bytes, and it raises no `reg_we` pulse.
- R4: A read of an undefined register returns 8'h00.
- R5: An address byte whose upper seven bits differ from `dev_addr` gets no ACK, and nothing is written for the rest of that transaction.
- R6: The general call address 7'h00 gets no ACK.
- R7: A write commits only at STOP. Two cases discard the pending data with no `reg_we` pulse: a repeated START after the data byte, or a second data byte. The second data byte gets no ACK.
- R8: An address byte with the read bit set that does not directly follow a pointer byte and a repeated START gets no ACK.
- R9: The alert response address 7'h0C with the read bit gets no ACK while no alert is pending.
- R10: A high `alert_req` drives `alert_n` low on the next clock. While it is pending, a read from 7'h0C gets ACK and returns `{dev_addr,1'b0}`. After the host's acknowledge bit, `alert_n` returns high.
- R11: `sda_oe` changes only while the raw `scl_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, pull SDA low |
| dev_addr | input | 7 | This slave's bus address |
| reg_addr | output | 8 | Register pointer to the register file |
| reg_wdata | output | 8 | Write data to the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Contents of the register at `reg_addr` |
| reg_defined | input | 1 | The register at `reg_addr` exists |
| alert_req | input | 1 | Request host service |
| alert_n | output | 1 | Active-low alert, pending service |

## Verification
A wrong state in the byte sequencer shows up within one bit time as an ACK in the wrong slot on SDA. It also shows up as a returned byte that disagrees with the bench's own register array. A pending write flag that is set or cleared wrongly only shows at STOP, as a missing or extra `reg_we` pulse. For that reason the bench checks the strobe against its permission window on every clock. A stale alert flag shows as `alert_n` staying low after the host's acknowledge bit, and as a wrongly acknowledged alert response.

// File: rtl/smb_reg_slave.sv
module smb_reg_slave #(
  parameter logic [6:0] ARA_ADDR = 7'h0C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [6:0] dev_addr,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata,
  input  logic       reg_defined,
  input  logic       alert_req,
  output logic       alert_n
);
  typedef enum logic [3:0] {S_IDLE, S_ADDR, S_ACK, S_REG, S_DATA, S_WSTOP, S_TX, S_TXACK, S_SKIP} st_t;
  typedef enum logic [1:0] {N_REG, N_DATA, N_WSTOP, N_TX} nx_t;

  logic [1:0] scl_s, sda_s;
  logic       scl_q, sda_q;
  st_t        st;
  nx_t        nx;
  logic [3:0] cnt;
  logic [7:0] sh, txsh;
  logic       rd_arm, wr_pend, alert_tx, pend;

  wire scl     = scl_s[1];
  wire sda     = sda_s[1];
  wire rise    = scl & ~scl_q;
  wire fall    = ~scl & scl_q;
  wire start_c = scl & scl_q & sda_q & ~sda;
  wire stop_c  = scl & scl_q & ~sda_q & sda;

  wire hit_w   = (sh[7:1] == dev_addr) && (sh[7:1] != 7'h00) && !sh[0];
  wire hit_r   = (sh[7:1] == dev_addr) && (sh[7:1] != 7'h00) && sh[0] && rd_arm;
  wire hit_ara = (sh[7:1] == ARA_ADDR) && sh[0] && pend;
  wire [7:0] tx_byte = alert_tx ? {dev_addr, 1'b0} : (reg_defined ? reg_rdata : 8'h00);

  assign alert_n = ~pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      nx        <= N_REG;
      cnt       <= '0;
      sh        <= '0;
      txsh      <= '0;
      sda_oe    <= 1'b0;
      rd_arm    <= 1'b0;
      wr_pend   <= 1'b0;
      alert_tx  <= 1'b0;
      pend      <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (start_c) begin
        rd_arm   <= (st == S_DATA) && (cnt <= 4'd1);
        st       <= S_ADDR;
        cnt      <= '0;
        sda_oe   <= 1'b0;
        wr_pend  <= 1'b0;
        alert_tx <= 1'b0;
      end else if (stop_c) begin
        if (st == S_WSTOP && wr_pend && reg_defined) reg_we <= 1'b1;
        wr_pend <= 1'b0;
        rd_arm  <= 1'b0;
        sda_oe  <= 1'b0;
        st      <= S_IDLE;
      end else begin
        case (st)
          S_ADDR, S_REG, S_DATA: begin
            if (rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda};
              cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                rd_arm <= 1'b0;
                if (hit_w) begin
                  sda_oe <= 1'b1; nx <= N_REG; st <= S_ACK;
                end else if (hit_r) begin
                  sda_oe <= 1'b1; nx <= N_TX; st <= S_ACK;
                end else if (hit_ara) begin
                  sda_oe <= 1'b1; nx <= N_TX; alert_tx <= 1'b1; st <= S_ACK;
                end else begin
                  st <= S_SKIP;
                end
              end else if (st == S_REG) begin
                reg_addr <= sh;
                sda_oe   <= 1'b1;
                nx       <= N_DATA;
                st       <= S_ACK;
              end else begin
                reg_wdata <= sh;
                wr_pend   <= 1'b1;
                sda_oe    <= 1'b1;
                nx        <= N_WSTOP;
                st        <= S_ACK;
              end
            end
          end
          S_ACK: begin
            if (fall) begin
              cnt <= '0;
              case (nx)
                N_REG:   begin sda_oe <= 1'b0; st <= S_REG;   end
                N_DATA:  begin sda_oe <= 1'b0; st <= S_DATA;  end
                N_WSTOP: begin sda_oe <= 1'b0; st <= S_WSTOP; end
                default: begin
                  txsh   <= tx_byte;
                  sda_oe <= ~tx_byte[7];
                  st     <= S_TX;
                end
              endcase
            end
          end
          S_TX: begin
            if (rise) begin
              cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8) begin
              sda_oe <= 1'b0;
              st     <= S_TXACK;
            end else if (fall && cnt != 4'd0) begin
              txsh   <= {txsh[6:0], 1'b0};
              sda_oe <= ~txsh[6];
            end
          end
          S_TXACK: begin
            if (rise) begin
              if (alert_tx) pend <= 1'b0;
              alert_tx <= 1'b0;
              st       <= S_SKIP;
            end
          end
          S_WSTOP: begin
            if (fall) begin
              wr_pend <= 1'b0;
              st      <= S_SKIP;
            end
          end
          default: ;
        endcase
      end
      if (alert_req) pend <= 1'b1;
    end
  end
endmodule

module smb_reg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic reg_we,
  input logic reg_defined,
  input logic alert_req,
  input logic alert_n
);
  AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) reg_we |=> !reg_we); // R1
  AST_WE_ONLY_DEFINED: assert property (@(posedge clk) disable iff (!rst_n) reg_we |-> reg_defined); // R3
  AST_ALERT_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n) alert_req |=> !alert_n); // R10
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_oe) |-> !scl_i); // R11
endmodule

bind smb_reg_slave smb_reg_slave_chk u_chk (.*);

// File: tb/smb_reg_slave_bench.sv
module smb_reg_slave_bench;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h2E;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_lo = 1'b0, alert_req = 1'b0;
  logic sda_oe, reg_we, reg_defined, alert_n;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  wire sda_line = !(sda_lo | sda_oe);

  int tests = 0, fails = 0, we_seen = 0, cyc = 0;
  logic we_ok = 1'b0;

  always #2 clk = ~clk;

  smb_reg_slave u_smb_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_addr(DEV), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .reg_defined(reg_defined),
    .alert_req(alert_req), .alert_n(alert_n));

  assign reg_defined = reg_addr < 8'h40;
  assign reg_rdata = mem[reg_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h3C;
    end else if (reg_we) mem[reg_addr] <= reg_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && reg_we) begin
      we_seen++;
      if (!we_ok) begin
        fails++;
        $display("FAIL R3/R5/R7 actual=reg_we expected=no strobe");
      end
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic w(); repeat (Q) @(negedge clk); endtask

  task automatic bstart();
    sda_lo = 0; w(); scl = 1; w(); sda_lo = 1; w(); scl = 0; w();
  endtask

  task automatic bstop();
    sda_lo = 1; w(); scl = 1; w(); sda_lo = 0; w(); w();
  endtask

  task automatic sbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_lo = !b[i]; w(); scl = 1; w(); w(); scl = 0; w();
    end
    sda_lo = 0; w(); scl = 1; w(); ack = !sda_line; w(); scl = 0; w();
  endtask

  task automatic rbyte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_lo = 0; w(); scl = 1; w(); b[i] = sda_line; w(); scl = 0; w();
    end
    sda_lo = 0; w(); scl = 1; w(); w(); scl = 0; w();
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                    output bit a1, output bit a2, output bit a3);
    bstart(); sbyte({a, 1'b0}, a1); sbyte(r, a2); sbyte(d, a3); bstop();
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] r, output logic [7:0] d,
                    output bit a1, output bit a2, output bit a3);
    bstart(); sbyte({a, 1'b0}, a1); sbyte(r, a2);
    bstart(); sbyte({a, 1'b1}, a3); rbyte(d); bstop();
  endtask

  initial begin
    bit a1, a2, a3, a4;
    logic [7:0] d;
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(alert_n && !sda_oe && !reg_we, "R10 reset", {alert_n, sda_oe, reg_we}, 3'b100);

    base = we_seen; we_ok = 1;
    wr(DEV, 8'h05, 8'hA5, a1, a2, a3);
    w(); we_ok = 0;
    chk(a1 && a2 && a3, "R1 acks", {a1, a2, a3}, 3'b111);
    chk(we_seen == base + 1, "R1 strobe count", we_seen - base, 1);
    chk(mem[5] == 8'hA5, "R1 stored", mem[5], 8'hA5);

    rd(DEV, 8'h05, d, a1, a2, a3);
    chk(a1 && a2 && a3, "R2 acks", {a1, a2, a3}, 3'b111);
    chk(d == 8'hA5, "R2 data", d, 8'hA5);
    rd(DEV, 8'h3F, d, a1, a2, a3);
    chk(d == (8'h3F ^ 8'h3C), "R2 data pattern", d, 8'h3F ^ 8'h3C);

    wr(DEV, 8'h40, 8'h77, a1, a2, a3);
    chk(a1 && a2 && a3, "R3 undefined write acked", {a1, a2, a3}, 3'b111);
    chk(mem[8'h40] == (8'h40 ^ 8'h3C), "R3 unchanged", mem[8'h40], 8'h40 ^ 8'h3C);

    rd(DEV, 8'h80, d, a1, a2, a3);
    chk(d == 8'h00, "R4 undefined read", d, 0);

    wr(7'h2F, 8'h06, 8'h11, a1, a2, a3);
    chk(!a1 && !a2 && !a3, "R5 wrong address", {a1, a2, a3}, 0);
    chk(mem[6] == (8'h06 ^ 8'h3C), "R5 unchanged", mem[6], 8'h06 ^ 8'h3C);

    wr(7'h00, 8'h06, 8'h11, a1, a2, a3);
    chk(!a1, "R6 general call", a1, 0);

    bstart(); sbyte({DEV, 1'b0}, a1); sbyte(8'h07, a2); sbyte(8'h99, a3);
    bstart(); bstop();
    chk(a3 && mem[7] == (8'h07 ^ 8'h3C), "R7 restart discards", mem[7], 8'h07 ^ 8'h3C);
    bstart(); sbyte({DEV, 1'b0}, a1); sbyte(8'h07, a2); sbyte(8'h99, a3); sbyte(8'h98, a4);
    bstop();
    chk(!a4, "R7 second data byte nacked", a4, 0);
    chk(mem[7] == (8'h07 ^ 8'h3C), "R7 two bytes discard", mem[7], 8'h07 ^ 8'h3C);

    bstart(); sbyte({DEV, 1'b1}, a1); bstop();
    chk(!a1, "R8 bare read", a1, 0);

    bstart(); sbyte({7'h0C, 1'b1}, a1); bstop();
    chk(!a1, "R9 ARA without alert", a1, 0);

    @(negedge clk) alert_req = 1;
    @(negedge clk) alert_req = 0;
    chk(!alert_n, "R10 alert asserted", alert_n, 0);
    bstart(); sbyte({7'h0C, 1'b1}, a1); rbyte(d); bstop();
    chk(a1, "R10 ARA acked", a1, 1);
    chk(d == {DEV, 1'b0}, "R10 ARA data", d, {DEV, 1'b0});
    chk(alert_n, "R10 alert released", alert_n, 1);

    base = we_seen; we_ok = 1;
    wr(DEV, 8'h00, 8'h5A, a1, a2, a3);
    w(); we_ok = 0;
    chk(mem[0] == 8'h5A && we_seen == base + 1, "R1 write after alert", mem[0], 8'h5A);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule